// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer with Capture and PWM

This block is an 8-bit timer/counter that runs in one of four modes chosen by a single control register. The modes are a periodic interval timer, a capture of the counter on a rising pin edge, a capture of the counter on a falling pin edge, and a free-running PWM generator. The count rate is either one of three fixed divisions of the system clock or the rising edges of an external pin. The same pin is the capture input.

Software uses a small register port to reach the block. It can write and read the control register and the data (compare/capture) register, and it can read the live counter value. There are two interrupt request lines. The match/capture request comes from a pending flag that only a software write can clear. The overflow request clears itself when the interrupt controller returns an acknowledge pulse.

Top module: `tmr8_multi`

## Requirements
- R1: After a synchronous reset, every control field is 0, the counter is 0, the data register is 0, and `bus_rdata`, `pwm_out`, `irq_match` and `irq_ovf` are all 0.
- R2: Control bits 7:6 choose the count rate. Code 00 gives one count per 4096 clocks, 01 gives one per 256 clocks and 10 gives one per 8 clocks. All three rates come from a single free-running divider that starts at 0 after reset. The count happens at the last clock of each period.
- R3: With control bits 7:6 = 11, the counter advances once for each rising edge of `ext_pin`. The edge takes effect three clocks after the pin changes, because of a two-stage synchronizer followed by an edge register.
- R4: With control bits 5:4 = 00 (interval), a count event that finds the counter equal to the data register sets the counter to 0 and sets the match/capture pending flag. Any other count event increments the counter.
- R5: With control bits 5:4 = 01 the capture happens on a synchronized rising edge of `ext_pin`; with 10 it happens on a falling edge. A capture copies the counter value into the data register and sets the pending flag. The counter keeps counting. A capture has priority over a bus write to the data register in the same clock.
- R6: With control bits 5:4 = 11 (PWM), the counter wraps freely. `pwm_out` is 1 one clock after the counter is below the data register, and 0 otherwise. A count event that finds the counter equal to the data register sets the pending flag. Outside PWM mode, `pwm_out` is 0.
- R7: A count event that takes the counter from 0xFF to 0x00 sets the overflow pending state, but only while control bit 2 is 1. `irq_ovf` is that state ANDed with bit 2, registered. A pulse on `ovf_ack` clears the state, and a new overflow in the same clock wins over the acknowledge.
- R8: Writing control with bit 3 = 1 sets the counter to 0 in that clock and overrides any count event. Bit 3 always reads back as 0, and writing 0 to it leaves the counter alone.
- R9: Control bit 0 is the match/capture pending flag. Writing 0 to it clears the flag and writing 1 leaves it unchanged. A hardware set in the same clock wins over the clear. `irq_match` is the flag ANDed with control bit 1, registered.
- R10: The register addresses are 0 = control, 1 = data and 2 = counter. The counter address is read-only, so a write to it has no effect. Address 3 reads 0. `bus_rdata` shows the register at `bus_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the source of the count divider |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous clock's address |
| ext_pin | input | 1 | External count clock and capture input, asynchronous |
| ovf_ack | input | 1 | Overflow interrupt service acknowledge |
| pwm_out | output | 1 | PWM waveform |
| irq_match | output | 1 | Match/capture interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The assertions assume three things about the inputs. The bus changes only between clock edges. `ext_pin` may change at any time, because it is consumed only after the synchronizer. `ovf_ack` is a pulse with no required relation to `irq_ovf`, although the properties would still hold if it were held high. To keep inside these limits, the stimulus drives every input on the falling clock edge. It toggles the pin at intervals longer than the synchronizer latency, so that every edge is seen. It raises `ovf_ack` for one clock only after it has observed `irq_ovf` high.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MD_INTERVAL = 2'b00,
    MD_CAP_RISE = 2'b01,
    MD_CAP_FALL = 2'b10,
    MD_PWM      = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    CS_SLOW = 2'b00,
    CS_MID  = 2'b01,
    CS_FAST = 2'b10,
    CS_PIN  = 2'b11
  } tmr_csel_e;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_CNT  = 2'd2;

  // control bit positions
  localparam int CB_PEND  = 0;
  localparam int CB_IEM   = 1;
  localparam int CB_IEO   = 2;
  localparam int CB_CLR   = 3;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
  parameter int SLOW_LOG2 = 12,
  parameter int MID_LOG2  = 8,
  parameter int FAST_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick_slow,
  output logic tick_mid,
  output logic tick_fast
);
  localparam int PW = SLOW_LOG2;

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign tick_slow = &div_q[SLOW_LOG2-1:0];
  assign tick_mid  = &div_q[MID_LOG2-1:0];
  assign tick_fast = &div_q[FAST_LOG2-1:0];
endmodule

// File: rtl/tmr8_pinsync.sv
module tmr8_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= pin;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_mode_e     mode,
  input  logic          tick,
  input  logic          clr,
  input  logic          edge_rise,
  input  logic          edge_fall,
  input  logic          data_we,
  input  logic [CW-1:0] data_wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] data,
  output logic          mc_evt,
  output logic          ovf_evt,
  output logic          pwm
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d, data_q, data_d;
  logic          cap;
  logic          pwm_q;

  always_comb begin
    cnt_d   = cnt_q;
    data_d  = data_q;
    mc_evt  = 1'b0;
    ovf_evt = 1'b0;
    cap     = ((mode == MD_CAP_RISE) && edge_rise) ||
              ((mode == MD_CAP_FALL) && edge_fall);
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if ((mode == MD_INTERVAL) && (cnt_q == data_q)) begin
        cnt_d  = '0;
        mc_evt = 1'b1;
      end else begin
        cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
        if (cnt_q == TOP) ovf_evt = 1'b1;
        if ((mode == MD_PWM) && (cnt_q == data_q)) mc_evt = 1'b1;
      end
    end
    if (cap) begin
      data_d = cnt_q;
      mc_evt = 1'b1;
    end else if (data_we) begin
      data_d = data_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      data_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      data_q <= data_d;
      pwm_q  <= (mode == MD_PWM) && (cnt_q < data_q);
    end
  end

  assign cnt  = cnt_q;
  assign data = data_q;
  assign pwm  = pwm_q;
endmodule

// File: rtl/tmr8_multi.sv
module tmr8_multi
  import tmr8_pkg::*;
#(
  parameter int CW        = 8,
  parameter int SLOW_LOG2 = 12,
  parameter int MID_LOG2  = 8,
  parameter int FAST_LOG2 = 3,
  parameter int SYNC_N    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          ext_pin,
  input  logic          ovf_ack,
  output logic          pwm_out,
  output logic          irq_match,
  output logic          irq_ovf
);
  tmr_csel_e     csel_q;
  tmr_mode_e     mode_q;
  logic          ieo_q, iem_q, pend_q, ovp_q;
  logic          irqm_q, irqo_q;
  logic [CW-1:0] rdata_q;

  logic          t_slow, t_mid, t_fast;
  logic          p_rise, p_fall;
  logic          tick, clr, ctrl_we, data_we;
  logic          mc_evt, ovf_evt, pwm;
  logic [CW-1:0] cnt, data;

  assign ctrl_we = bus_we && (bus_addr == RA_CTRL);
  assign data_we = bus_we && (bus_addr == RA_DATA);
  assign clr     = ctrl_we && bus_wdata[CB_CLR];

  tmr8_prescale #(
    .SLOW_LOG2(SLOW_LOG2), .MID_LOG2(MID_LOG2), .FAST_LOG2(FAST_LOG2)
  ) u_pre (
    .clk(clk), .rst(rst),
    .tick_slow(t_slow), .tick_mid(t_mid), .tick_fast(t_fast)
  );

  tmr8_pinsync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .rise(p_rise), .fall(p_fall)
  );

  always_comb begin
    unique case (csel_q)
      CS_SLOW: tick = t_slow;
      CS_MID:  tick = t_mid;
      CS_FAST: tick = t_fast;
      default: tick = p_rise;
    endcase
  end

  tmr8_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .mode(mode_q), .tick(tick), .clr(clr),
    .edge_rise(p_rise), .edge_fall(p_fall),
    .data_we(data_we), .data_wdata(bus_wdata),
    .cnt(cnt), .data(data), .mc_evt(mc_evt), .ovf_evt(ovf_evt), .pwm(pwm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csel_q <= CS_SLOW;
      mode_q <= MD_INTERVAL;
      ieo_q  <= 1'b0;
      iem_q  <= 1'b0;
      pend_q <= 1'b0;
      ovp_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        csel_q <= tmr_csel_e'(bus_wdata[7:6]);
        mode_q <= tmr_mode_e'(bus_wdata[5:4]);
        ieo_q  <= bus_wdata[CB_IEO];
        iem_q  <= bus_wdata[CB_IEM];
      end
      if (mc_evt)                              pend_q <= 1'b1;
      else if (ctrl_we && !bus_wdata[CB_PEND]) pend_q <= 1'b0;
      if (ovf_evt && ieo_q) ovp_q <= 1'b1;
      else if (ovf_ack)     ovp_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqm_q  <= 1'b0;
      irqo_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      irqm_q <= pend_q & iem_q;
      irqo_q <= ovp_q & ieo_q;
      unique case (bus_addr)
        RA_CTRL: rdata_q <= {csel_q, mode_q, 1'b0, ieo_q, iem_q, pend_q};
        RA_DATA: rdata_q <= data;
        RA_CNT:  rdata_q <= cnt;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pwm_out   = pwm;
  assign irq_match = irqm_q;
  assign irq_ovf   = irqo_q;
endmodule

// File: rtl/tmr8_multi_chk.sv
module tmr8_multi_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [CW-1:0] bus_wdata,
  input logic [CW-1:0] bus_rdata,
  input logic          pwm_out,
  input logic          irq_ovf,
  input logic [1:0]    mode,
  input logic          ieo,
  input logic          pend,
  input logic [CW-1:0] cnt
);
  // R9
  pend_sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> $past(bus_we && bus_addr == 2'd0 && !bus_wdata[0]));

  // R8
  clear_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd0 && bus_wdata[3]) |=> (cnt == '0));

  // R8
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == 2'd0) |-> !bus_rdata[3]);

  // R6
  pwm_mode_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) != 2'b11) |-> !pwm_out);

  // R7
  ovf_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ovf |-> $past(ieo));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) || (cnt == $past(cnt)) || ({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1));

  // R10
  cnt_readonly_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd2 && $stable(cnt)) |=> ((cnt == $past(cnt)) ||
      ({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) || (cnt == '0)));
endmodule

bind tmr8_multi tmr8_multi_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
  .irq_ovf(irq_ovf), .mode(mode_q), .ieo(ieo_q), .pend(pend_q), .cnt(cnt)
);

// File: tb/tmr8_multi_bench.sv
`timescale 1ns/1ps
module tmr8_multi_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_pin = 1'b0;
  logic       ovf_ack = 1'b0;
  logic       pwm_out, irq_match, irq_ovf;

  always #5 clk = ~clk;

  tmr8_multi u_tmr8_multi (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .ovf_ack(ovf_ack), .pwm_out(pwm_out), .irq_match(irq_match),
    .irq_ovf(irq_ovf)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    m_valid = 0;

  // reference state
  int m_csel, m_mode, m_ieo, m_iem, m_pend, m_ovp, m_cnt, m_data, m_pc;
  int s1, s2, s3;
  int e_irqm, e_irqo, e_pwm, e_rd;

  always @(posedge clk) begin
    int tick, rise, fall, clr, mc, ov, cap, ncnt, ndata, wctl;
    cyc++;
    if (rst) begin
      m_csel = 0; m_mode = 0; m_ieo = 0; m_iem = 0; m_pend = 0; m_ovp = 0;
      m_cnt = 0; m_data = 0; m_pc = 0; s1 = 0; s2 = 0; s3 = 0;
      e_irqm = 0; e_irqo = 0; e_pwm = 0; e_rd = 0;
      m_valid = 1;
    end else begin
      e_irqm = m_pend & m_iem;
      e_irqo = m_ovp & m_ieo;
      e_pwm  = (m_mode == 3 && m_cnt < m_data) ? 1 : 0;
      case (bus_addr)
        2'd0: e_rd = m_csel * 64 + m_mode * 16 + m_ieo * 4 + m_iem * 2 + m_pend;
        2'd1: e_rd = m_data;
        2'd2: e_rd = m_cnt;
        default: e_rd = 0;
      endcase
      rise = (s2 == 1 && s3 == 0) ? 1 : 0;
      fall = (s2 == 0 && s3 == 1) ? 1 : 0;
      case (m_csel)
        0: tick = (m_pc % 4096 == 4095) ? 1 : 0;
        1: tick = (m_pc % 256 == 255) ? 1 : 0;
        2: tick = (m_pc % 8 == 7) ? 1 : 0;
        default: tick = rise;
      endcase
      wctl = (bus_we && bus_addr == 2'd0) ? 1 : 0;
      clr = (wctl && bus_wdata[3]) ? 1 : 0;
      mc = 0; ov = 0; ncnt = m_cnt; ndata = m_data;
      if (clr) ncnt = 0;
      else if (tick) begin
        if (m_mode == 0 && m_cnt == m_data) begin ncnt = 0; mc = 1; end
        else begin
          ncnt = (m_cnt + 1) % 256;
          if (m_cnt == 255) ov = 1;
          if (m_mode == 3 && m_cnt == m_data) mc = 1;
        end
      end
      cap = ((m_mode == 1 && rise) || (m_mode == 2 && fall)) ? 1 : 0;
      if (cap) begin ndata = m_cnt; mc = 1; end
      else if (bus_we && bus_addr == 2'd1) ndata = bus_wdata;
      if (mc) m_pend = 1;
      else if (wctl && !bus_wdata[0]) m_pend = 0;
      if (ov && m_ieo) m_ovp = 1;
      else if (ovf_ack) m_ovp = 0;
      if (wctl) begin
        m_csel = bus_wdata[7:6]; m_mode = bus_wdata[5:4];
        m_ieo = bus_wdata[2]; m_iem = bus_wdata[1];
      end
      m_cnt = ncnt; m_data = ndata;
      m_pc = (m_pc + 1) % 4096;
      s3 = s2; s2 = s1; s1 = ext_pin;
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic cmp(input string what, input int act, input int exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid) begin
      cmp("irq_match", int'(irq_match), e_irqm);
      cmp("irq_ovf", int'(irq_ovf), e_irqo);
      cmp("pwm_out", int'(pwm_out), e_pwm);
      cmp("bus_rdata", int'(bus_rdata), e_rd);
    end
    // acknowledge each overflow request it sees, for one clock
    ovf_ack <= irq_ovf && !ovf_ack;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int n);
    @(negedge clk);
    bus_addr = a;
    idle(n);
  endtask

  task automatic pin_toggle(input int count, input int half);
    for (int i = 0; i < count; i++) begin
      idle(half);
      ext_pin = ~ext_pin;
    end
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(4);
    rst = 1'b0;
    rd(2'd0, 3); rd(2'd1, 3); rd(2'd2, 3);

    // R10: register map, counter write ignored, address 3 reads zero
    cur_req = "R10";
    wr(2'd1, 8'h5A); rd(2'd1, 3);
    wr(2'd2, 8'h77); rd(2'd2, 3);
    rd(2'd3, 3); rd(2'd1, 2);

    // R4: interval mode, fast rate, compare 0x10, match irq enabled
    cur_req = "R4";
    wr(2'd1, 8'h10);
    wr(2'd0, 8'b10_00_0_0_1_0);
    rd(2'd2, 400);
    rd(2'd0, 50);

    // R9: write 1 to pending keeps it, write 0 clears it
    cur_req = "R9";
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'b10_00_0_0_1_1);
    rd(2'd0, 4);
    wr(2'd0, 8'b10_00_0_0_1_0);
    rd(2'd0, 6);

    // R8: clear strobe while counting
    cur_req = "R8";
    rd(2'd2, 100);
    wr(2'd0, 8'b10_00_1_0_1_0);
    rd(2'd2, 20);
    wr(2'd0, 8'b10_00_0_0_1_0);
    rd(2'd2, 20);

    // R2: mid and slow rates
    cur_req = "R2";
    wr(2'd1, 8'h03);
    wr(2'd0, 8'b01_00_1_0_1_0);
    rd(2'd2, 2200);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'b00_00_1_0_1_0);
    rd(2'd2, 13000);

    // R6 / R7: PWM with fast rate, overflow irq enabled
    cur_req = "R6";
    wr(2'd1, 8'h80);
    wr(2'd0, 8'b10_11_1_1_1_0);
    rd(2'd2, 2100);
    cur_req = "R7";
    rd(2'd0, 3000);
    wr(2'd0, 8'b10_11_0_1_1_0);
    rd(2'd2, 2200);
    // overflow enable off: no overflow request
    wr(2'd0, 8'b10_00_1_0_0_0);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'b10_01_1_0_0_0);
    rd(2'd2, 2200);

    // R3: external pin counting in interval mode
    cur_req = "R3";
    wr(2'd1, 8'h06);
    wr(2'd0, 8'b11_00_1_0_1_0);
    bus_addr = 2'd2;
    pin_toggle(40, 5);
    pin_toggle(10, 2);

    // R5: capture on rising, then falling, with the fast rate
    cur_req = "R5";
    wr(2'd0, 8'b10_01_1_0_1_0);
    bus_addr = 2'd1;
    pin_toggle(12, 37);
    wr(2'd0, 8'b10_10_0_0_1_0);
    bus_addr = 2'd1;
    pin_toggle(12, 29);
    // capture with pin as count clock too
    wr(2'd0, 8'b11_01_1_0_1_0);
    bus_addr = 2'd1;
    pin_toggle(20, 4);
    // capture against a bus data write in the same window
    wr(2'd0, 8'b10_10_0_0_1_0);
    for (int k = 0; k < 6; k++) begin
      idle(9);
      ext_pin = ~ext_pin;
      idle(2);
      wr(2'd1, 8'hC3);
      rd(2'd1, 2);
    end

    // R6: PWM on external pin, small compare
    cur_req = "R6";
    wr(2'd1, 8'h02);
    wr(2'd0, 8'b11_11_1_0_1_0);
    bus_addr = 2'd0;
    pin_toggle(600, 3);

    // R1: reset again mid-activity
    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    idle(3);
    rst = 1'b0;
    rd(2'd0, 3); rd(2'd2, 3);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule